// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block turns a single configuration access, either a read or a write, into the short packet that a PCIe root-port transmit path expects. It is given the target bus, device/function, byte offset, access size, write data and the bus number the root port currently owns. From these it works out the byte enables and places the write data in the correct byte lanes of the dword. It then builds a three-dword request header and sends the packet out as 64-bit beats. Each beat is marked with start and end flags, and a valid/ready handshake paces the output.

A caller presents a request when `req_ready_o` is high and holds nothing afterwards: the block keeps every beat it needs. A read or an unaligned write leaves as two beats. A write whose offset is quadword aligned gets an extra beat, so that its payload lands in the low half of the last beat. A one-cycle `done_o` pulse follows acceptance of the final beat. Collecting the completion is left to a separate receive path.

Top module: `cfg_req_packer`

## Requirements
- R1: The header format/type byte is 0x04 for a read and 0x44 for a write when the target bus equals the root bus number. It is 0x05 for a read and 0x45 for a write when the two differ.
- R2: Header dword 0 holds the format/type byte in bits 31:24 and the value 1 in the length field, bits 9:0. All its other bits are zero.
- R3: Header dword 1 holds the requester ID {root bus, 8'h00} in bits 31:16 and the tag in bits 15:8. The tag is 0x1D for reads and 0x10 for writes. Bits 7:4 are zero and the byte enables sit in bits 3:0.
- R4: The byte enables are 4'b0001 shifted left by offset[1:0] for a size of 1, and 4'b0011 shifted left by offset[1:0] (truncated to 4 bits) for a size of 2. Any other size value counts as a 4-byte access and gives 4'hF.
- R5: The write payload is the write data masked to the access size and then shifted left by 8 × offset[1:0], truncated to 32 bits. A read carries a payload of zero.
- R6: Header dword 2 holds the target bus in bits 31:24 and the devfn in bits 23:16. Its bits 15:0 hold the offset with bits 1:0 cleared.
- R7: A read, or a write with offset[2:0] != 0, goes out as two beats. The first beat is {dword1, dword0} with SOP set. The second is {payload, dword2} with EOP set.
- R8: A write with offset[2:0] == 0 goes out as three beats. The first is {dword1, dword0} with SOP set. The second is {32'h0, dword2} with neither flag set. The third is {32'h0, payload} with EOP set.
- R9: `req_ready_o` is high only while no packet is pending. A request offered while a packet is pending is ignored and produces no beats.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, the beat and its flags stay unchanged into the next cycle.
- R11: `done_o` is high for exactly the one cycle after the EOP beat is accepted, and is low at all other times.
- R12: After reset, `tx_valid_o` and `done_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_devfn_i | input | 8 | Target device/function |
| req_offset_i | input | OFF_W | Byte offset into configuration space |
| req_size_i | input | 3 | Access size in bytes (1, 2, other = 4) |
| req_wdata_i | input | 32 | Write data, right aligned |
| root_bus_i | input | 8 | Bus number owned by the root port |
| tx_valid_o | output | 1 | Beat valid |
| tx_ready_i | input | 1 | Downstream accepts beat |
| tx_data_o | output | 64 | Beat, first dword in bits 31:0 |
| tx_sop_o | output | 1 | First beat of packet |
| tx_eop_o | output | 1 | Last beat of packet |
| done_o | output | 1 | Pulse after last beat accepted |

## Verification
The bench builds the block with its default 12-bit offset. This covers the full extended configuration space, so a quadword-aligned write near the 4 KiB ceiling checks that the upper offset bits reach header dword 2. The 12-bit width also keeps every lane, size and alignment combination within reach. The downstream ready signal runs both always high and with periodic stalls, so beats are checked both while they are held and as they pass back to back.

// File: rtl/cfgpkt_pkg.sv
package cfgpkt_pkg;
  localparam int unsigned NBEAT   = 3;
  localparam int unsigned BEAT_W  = 64;
  localparam int unsigned DW_W    = 32;
  localparam int unsigned IDX_W   = $clog2(NBEAT);

  localparam logic [7:0] FMT_RD_LOCAL  = 8'h04;
  localparam logic [7:0] FMT_WR_LOCAL  = 8'h44;
  localparam logic [7:0] FMT_RD_REMOTE = 8'h05;
  localparam logic [7:0] FMT_WR_REMOTE = 8'h45;
  localparam logic [7:0] TAG_RD        = 8'h1D;
  localparam logic [7:0] TAG_WR        = 8'h10;
  localparam logic [9:0] LEN_ONE_DW    = 10'd1;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic              sop;
    logic              eop;
  } beat_t;
endpackage

// File: rtl/cfg_hdr_calc.sv
module cfg_hdr_calc
  import cfgpkt_pkg::*;
#(
  parameter int unsigned OFF_W = 12
) (
  input  logic             write_i,
  input  logic [7:0]       bus_i,
  input  logic [7:0]       devfn_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [2:0]       size_i,
  input  logic [DW_W-1:0]  wdata_i,
  input  logic [7:0]       root_bus_i,
  output beat_t            beat_o [NBEAT],
  output logic             three_o
);
  localparam int unsigned PAD_W = 16 - OFF_W;

  logic [1:0]      lane;
  logic [3:0]      be;
  logic [DW_W-1:0] mask;
  logic [DW_W-1:0] payload;
  logic [7:0]      fmt;
  logic [7:0]      tag;
  logic [15:0]     off_dw;
  logic [DW_W-1:0] dw0, dw1, dw2;
  logic            qalign;

  assign lane = offset_i[1:0];

  always_comb begin
    unique case (size_i)
      3'd1:    begin be = 4'b0001 << lane; mask = 32'h0000_00FF; end
      3'd2:    begin be = 4'b0011 << lane; mask = 32'h0000_FFFF; end
      default: begin be = 4'b1111;         mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign payload = write_i ? ((wdata_i & mask) << {lane, 3'b000}) : '0;

  always_comb begin
    if (bus_i == root_bus_i) fmt = write_i ? FMT_WR_LOCAL  : FMT_RD_LOCAL;
    else                     fmt = write_i ? FMT_WR_REMOTE : FMT_RD_REMOTE;
  end

  assign tag    = write_i ? TAG_WR : TAG_RD;
  assign off_dw = {{PAD_W{1'b0}}, offset_i[OFF_W-1:2], 2'b00};

  assign dw0 = {fmt, 14'd0, LEN_ONE_DW};
  assign dw1 = {root_bus_i, 8'h00, tag, 4'h0, be};
  assign dw2 = {bus_i, devfn_i, off_dw};

  // aligned writes push the payload into its own beat
  assign qalign  = write_i && (offset_i[2:0] == 3'b000);
  assign three_o = qalign;

  always_comb begin
    beat_o[0] = '{data: {dw1, dw0}, sop: 1'b1, eop: 1'b0};
    if (qalign) begin
      beat_o[1] = '{data: {32'h0, dw2},     sop: 1'b0, eop: 1'b0};
      beat_o[2] = '{data: {32'h0, payload}, sop: 1'b0, eop: 1'b1};
    end else begin
      beat_o[1] = '{data: {payload, dw2},   sop: 1'b0, eop: 1'b1};
      beat_o[2] = '0;
    end
  end
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
  import cfgpkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  beat_t            beat_i [NBEAT],
  input  logic [IDX_W-1:0] last_i,
  output logic             idle_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output beat_t            tx_beat_o,
  output logic             done_o
);
  beat_t            beat_q [NBEAT];
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic             done_q;
  logic             take;

  for (genvar g = 0; g < NBEAT; g++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     beat_q[g] <= '0;
      else if (load_i) beat_q[g] <= beat_i[g];
    end
  end

  assign take = busy_q && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        last_q <= last_i;
      end else if (take) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign idle_o     = !busy_q;
  assign tx_valid_o = busy_q;
  assign tx_beat_o  = beat_q[idx_q];
  assign done_o     = done_q;
endmodule

// File: rtl/cfg_req_packer.sv
module cfg_req_packer
  import cfgpkt_pkg::*;
#(
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [7:0]       req_bus_i,
  input  logic [7:0]       req_devfn_i,
  input  logic [OFF_W-1:0] req_offset_i,
  input  logic [2:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  input  logic [7:0]       root_bus_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [63:0]      tx_data_o,
  output logic             tx_sop_o,
  output logic             tx_eop_o,
  output logic             done_o
);
  beat_t            beats [NBEAT];
  beat_t            cur;
  logic             three;
  logic             idle;
  logic [IDX_W-1:0] last_idx;

  cfg_hdr_calc #(.OFF_W(OFF_W)) u_hdr (
    .write_i   (req_write_i),
    .bus_i     (req_bus_i),
    .devfn_i   (req_devfn_i),
    .offset_i  (req_offset_i),
    .size_i    (req_size_i),
    .wdata_i   (req_wdata_i),
    .root_bus_i(root_bus_i),
    .beat_o    (beats),
    .three_o   (three)
  );

  assign last_idx = three ? IDX_W'(2) : IDX_W'(1);

  cfg_beat_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (req_valid_i && idle),
    .beat_i    (beats),
    .last_i    (last_idx),
    .idle_o    (idle),
    .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i),
    .tx_beat_o (cur),
    .done_o    (done_o)
  );

  assign req_ready_o = idle;
  assign tx_data_o   = cur.data;
  assign tx_sop_o    = cur.sop;
  assign tx_eop_o    = cur.eop;
endmodule

// File: rtl/cfg_req_packer_chk.sv
module cfg_req_packer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [63:0] tx_data_o,
  input logic        tx_sop_o,
  input logic        tx_eop_o,
  input logic        done_o
);
  assert_beat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_sop_o) && $stable(tx_eop_o));

  assert_done_after_eop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_eop_o |=> done_o);

  assert_done_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o && !tx_valid_o);

  assert_busy_blocks_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !req_ready_o);

  assert_accept_starts_sop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> tx_valid_o && tx_sop_o);

  assert_sop_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_sop_o |-> tx_data_o[9:0] == 10'd1 && !tx_eop_o);

  assert_fmt_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_sop_o |-> tx_data_o[31:24] inside {8'h04, 8'h05, 8'h44, 8'h45});
endmodule

bind cfg_req_packer cfg_req_packer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_sop_o   (tx_sop_o),
  .tx_eop_o   (tx_eop_o),
  .done_o     (done_o)
);

// File: tb/cfg_req_packer_tb.sv
module cfg_req_packer_tb;
  import cfgpkt_pkg::*;

  localparam int OFF_W = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic             req_write_i = 1'b0;
  logic [7:0]       req_bus_i = '0;
  logic [7:0]       req_devfn_i = '0;
  logic [OFF_W-1:0] req_offset_i = '0;
  logic [2:0]       req_size_i = '0;
  logic [31:0]      req_wdata_i = '0;
  logic [7:0]       root_bus_i = '0;
  logic             tx_valid_o;
  logic             tx_ready_i = 1'b1;
  logic [63:0]      tx_data_o;
  logic             tx_sop_o;
  logic             tx_eop_o;
  logic             done_o;

  int tests = 0;
  int fails = 0;
  int rdy_mode = 0;
  int cyc = 0;
  bit finished = 0;
  beat_t exp_q[$];

  always #10 clk_i = ~clk_i;

  cfg_req_packer #(.OFF_W(OFF_W)) u_dut (.*);

  always @(posedge clk_i) begin
    #5;
    cyc++;
    tx_ready_i = (rdy_mode == 0) || (cyc % 3 != 1);
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic void model(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                                input logic [OFF_W-1:0] off, input logic [2:0] sz,
                                input logic [31:0] wd, input logic [7:0] root);
    logic [3:0]  be;
    logic [31:0] pl, h0, h1, h2;
    logic [7:0]  ft;
    int          sh;
    sh = 8 * int'(off[1:0]);
    if (sz == 3'd1) begin be = 4'(4'd1 << off[1:0]); pl = 32'((wd & 32'hFF) << sh); end
    else if (sz == 3'd2) begin be = 4'(4'd3 << off[1:0]); pl = 32'((wd & 32'hFFFF) << sh); end
    else begin be = 4'hF; pl = wd; end
    if (!wr) pl = 32'h0;
    ft = (wr ? 8'h44 : 8'h04) | ((bus == root) ? 8'h00 : 8'h01);
    h0 = {ft, 24'h000001};
    h1 = {root, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, be};
    h2 = {bus, devfn, 4'h0, off[OFF_W-1:2], 2'b00};
    exp_q.push_back('{data: {h1, h0}, sop: 1'b1, eop: 1'b0});
    if (wr && off[2:0] == 3'd0) begin
      exp_q.push_back('{data: {32'h0, h2}, sop: 1'b0, eop: 1'b0});
      exp_q.push_back('{data: {32'h0, pl}, sop: 1'b0, eop: 1'b1});
    end else begin
      exp_q.push_back('{data: {pl, h2}, sop: 1'b0, eop: 1'b1});
    end
  endfunction

  task automatic send(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                      input logic [OFF_W-1:0] off, input logic [2:0] sz,
                      input logic [31:0] wd, input logic [7:0] root, input bit junk);
    do begin @(posedge clk_i); #5; end while (!req_ready_o);
    req_valid_i = 1'b1; req_write_i = wr; req_bus_i = bus; req_devfn_i = devfn;
    req_offset_i = off; req_size_i = sz; req_wdata_i = wd; root_bus_i = root;
    model(wr, bus, devfn, off, sz, wd, root);
    @(posedge clk_i); #5;
    if (junk) begin
      // R9: offered while busy, must produce nothing
      req_write_i = ~wr; req_bus_i = 8'hEE; req_offset_i = 12'h0A4; req_wdata_i = 32'hDEADBEEF;
      @(posedge clk_i); #5;
    end
    req_valid_i = 1'b0;
  endtask

  beat_t prev;
  bit    stall = 0;
  bit    pend_done = 0;

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (tx_valid_o && req_ready_o)
        chk(0, "R9 ready high while busy", {63'd0, req_ready_o}, 64'd0);
      if (stall)
        chk(tx_valid_o && tx_data_o == prev.data && tx_sop_o == prev.sop && tx_eop_o == prev.eop,
            "R10 stalled beat changed", tx_data_o, prev.data);
      if (pend_done)
        chk(done_o, "R11 done missing", {63'd0, done_o}, 64'd1);
      else if (done_o)
        chk(0, "R11 stray done", 64'd1, 64'd0);
      pend_done = 0;
      stall = tx_valid_o && !tx_ready_i;
      prev = '{data: tx_data_o, sop: tx_sop_o, eop: tx_eop_o};
      if (tx_valid_o && tx_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected beat", tx_data_o, 64'd0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          if (e.sop) begin
            chk(tx_data_o[31:0] == e.data[31:0], "R1 R2 header dword0", {32'd0, tx_data_o[31:0]}, {32'd0, e.data[31:0]});
            chk(tx_data_o[63:32] == e.data[63:32], "R3 R4 header dword1", {32'd0, tx_data_o[63:32]}, {32'd0, e.data[63:32]});
          end else begin
            chk(tx_data_o == e.data, "R5 R6 R7 R8 dword2/payload beat", tx_data_o, e.data);
          end
          chk(tx_sop_o == e.sop && tx_eop_o == e.eop, "R7 R8 beat flags",
              {62'd0, tx_sop_o, tx_eop_o}, {62'd0, e.sop, e.eop});
          if (tx_eop_o) pend_done = 1;
        end
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 64'd0, 64'd1);
      summary();
      $finish;
    end
  end

  initial begin
    #25;
    chk(!tx_valid_o && !done_o && req_ready_o, "R12 reset state",
        {61'd0, tx_valid_o, done_o, req_ready_o}, 64'd1);
    @(negedge clk_i); rst_ni = 1'b1;
    // ready always high
    send(0, 8'h00, 8'h00, 12'h010, 3'd4, 32'h0,        8'h00, 0); // R1 local read
    send(0, 8'h03, 8'h28, 12'h013, 3'd1, 32'h0,        8'h00, 0); // R4 remote byte read
    send(1, 8'h00, 8'h00, 12'h008, 3'd4, 32'hA1B2C3D4, 8'h00, 0); // R8 aligned write
    send(1, 8'h05, 8'h11, 12'h004, 3'd4, 32'h01234567, 8'h02, 0); // R7 unaligned write
    send(1, 8'h05, 8'h11, 12'h006, 3'd2, 32'hFFFF5AA5, 8'h02, 1); // R5 R9 half write lane 2
    send(1, 8'h02, 8'h09, 12'h010, 3'd1, 32'h123456C3, 8'h02, 0); // R4 R8 aligned byte
    send(1, 8'h07, 8'h3F, 12'h020, 3'd3, 32'hCAFEF00D, 8'h01, 0); // R4 odd size as 4
    send(1, 8'h07, 8'h3F, 12'h003, 3'd2, 32'h0000BEEF, 8'h01, 0); // R4 R5 truncated lanes
    send(1, 8'hFF, 8'hF8, 12'hFF8, 3'd4, 32'h87654321, 8'h10, 0); // R6 high offset
    // stalled ready
    rdy_mode = 1;
    send(1, 8'h10, 8'h00, 12'h018, 3'd4, 32'h55AA55AA, 8'h10, 1); // R10 R8
    send(0, 8'h11, 8'h08, 12'h102, 3'd2, 32'h0,        8'h10, 0); // R10 R7
    send(1, 8'h11, 8'h08, 12'h101, 3'd1, 32'h000000E7, 8'h10, 0); // R10 R5
    send(0, 8'h10, 8'h00, 12'hFFE, 3'd0, 32'h0,        8'h10, 0); // R6 R1
    repeat (10) @(posedge clk_i);
    #5;
    chk(exp_q.size() == 0, "R7 R8 beats missing", 64'(exp_q.size()), 64'd0);
    chk(req_ready_o && !tx_valid_o, "R11 idle at end", {62'd0, req_ready_o, tx_valid_o}, 64'd2);
    finished = 1;
    summary();
    $finish;
  end
endmodule